// File: doc/BRIEF.md
# Interleaved DRAM Address De-normalizer

A memory controller channel sees only a compacted, channel-local address from which the interleave bits of the system address have been removed. This block rebuilds the system physical address from that compacted address. It is used when a memory error is reported against a channel-local location and the system address has to be recovered.

Each request carries the channel-local address, the local chip-select ID, a flag that picks the older or the newer register layout, and four raw 32-bit configuration words: offset, base, limit and hole. The block first strips an optional high offset. It then decodes the interleave configuration and opens a gap for the interleave bits, either as one contiguous run or split across two places. Finally it adds the DRAM base, applies the legacy MMIO hole correction, fills in the chip-select ID when no hashing is active, and checks the result against the limit.

The result and an error flag appear one clock cycle after the request, qualified by a valid strobe. Hash correction and derivation of the chip-select ID are done outside this block.

Top module: `dram_addr_denorm`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `out_valid` is low.
- R2: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. The address and error flag of that request are presented with it.
- R3: When bit 0 of the offset word is set, the offset is taken from offset-word bits 31:20 (legacy) or 31:12 (new). The offset is right-aligned, placed so that its lowest bit lands at address bit 28, and subtracted from the address.
- R4: The offset is not subtracted when bit 0 of the offset word is clear, or when the address is below the offset.
- R5: The channel code is read from base-word bits 7:4 (legacy) or 5:2 (new). The select field is read from base-word bits 10:8 (legacy) or 11:9 (new). Die bits come from limit bits 11:10 (legacy) or base bits 7:6 (new). The socket bit comes from limit bit 8 (legacy) or base bit 8 (new). Channel codes decode as follows: 0 gives 0 bits, 1 gives 1, 3 gives 2, 5 gives 3 and 7 gives 4. Code 8 gives 1 hashed bit in legacy and 5 plain bits in new. Code 12 gives 1 hashed bit, 13 gives 2 hashed split bits and 14 gives 3 hashed split bits.
- R6: Any channel code not listed in R5 raises `out_err`.
- R7: The gap start bit is the select field plus 8. When hashing is active and the start bit is neither 8 nor 9, `out_err` is raised.
- R8: When the total number of interleave bits (channel + die + socket) exceeds 4, `out_err` is raised.
- R9: In contiguous mode, address bits below the start bit are kept in place and bits at and above it move up by the total count.
- R10: In split mode, bits 11 and up move up by the total count, bits 10 down to the start bit move up by one, and lower bits are kept in place.
- R11: The base (base-word bits 31:12 placed at address bits 47:28) is added. When no hashing is active and the channel bit count is non-zero, the chip-select ID is then ORed in at the start bit.
- R12: When base-word bit 1 is set and the address after the base add is at or above the hole base (hole-word bits 31:24 at address bits 31:24), the value 4 GiB minus the hole base is added.
- R13: The limit is limit-word bits 31:12 at address bits 47:28, with bits 27:0 all ones. A final address above the limit raises `out_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_legacy | input | 1 | 1 selects the older register layout |
| in_norm_addr | input | ADDR_W | Channel-local address |
| in_cs_id | input | CS_W | Local chip-select ID |
| in_offset_word | input | 32 | Raw offset configuration word |
| in_base_word | input | 32 | Raw base and interleave configuration word |
| in_limit_word | input | 32 | Raw limit configuration word |
| in_hole_word | input | 32 | Raw MMIO hole configuration word |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_sys_addr | output | ADDR_W | Rebuilt system address |
| out_err | output | 1 | Configuration or limit error |

## Verification
The bench builds the block with ADDR_W = 48, CS_W = 4 and MAX_ILV = 4. This is the narrowest address the base and limit fields fit in, and it lets a 4-bit chip-select ID fill every gap position. With this width, an address near the top of the limit check can be reached with short constants. Setting MAX_ILV to 4 puts the boundary between a legal 4-bit gap and an illegal 5-bit gap within reach, in both layouts.

// File: rtl/dram_addr_denorm_pkg.sv
package dram_addr_denorm_pkg;

   localparam int OFS_ALIGN_BIT = 28;
   localparam int SPLIT_HI_BIT  = 11;
   localparam int SEL_BASE_BIT  = 8;

   typedef struct packed {
      logic [2:0] chan;
      logic [1:0] dies;
      logic       sock;
      logic [3:0] start;
      logic       hashed;
      logic       split;
   } ilv_cfg_t;

endpackage

// File: rtl/dram_addr_denorm_ofs.sv
module dram_addr_denorm_ofs #(
   parameter int ADDR_W = 48
) (
   input  logic              legacy,
   input  logic [31:0]       ofs_word,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [ADDR_W-1:0] addr_o
);
   import dram_addr_denorm_pkg::*;

   logic [31:0]       field;
   logic [ADDR_W-1:0] ofs;

   always_comb begin
      if (legacy) field = {20'd0, ofs_word[31:20]};
      else        field = {12'd0, ofs_word[31:12]};
      ofs = ADDR_W'(field) << OFS_ALIGN_BIT;
      if (ofs_word[0] && (addr_i >= ofs)) addr_o = addr_i - ofs;
      else                                addr_o = addr_i;
   end

endmodule

// File: rtl/dram_addr_denorm_dec.sv
module dram_addr_denorm_dec #(
   parameter int MAX_ILV = 4
) (
   input  logic                          legacy,
   input  logic [31:0]                   base_word,
   input  logic [31:0]                   limit_word,
   output dram_addr_denorm_pkg::ilv_cfg_t cfg,
   output logic [3:0]                    total,
   output logic                          err
);
   import dram_addr_denorm_pkg::*;

   logic [3:0] code;
   logic [2:0] sel;
   logic       bad_code;

   always_comb begin
      cfg      = '0;
      bad_code = 1'b0;
      if (legacy) begin
         code     = base_word[7:4];
         sel      = base_word[10:8];
         cfg.dies = limit_word[11:10];
         cfg.sock = limit_word[8];
      end else begin
         code     = base_word[5:2];
         sel      = base_word[11:9];
         cfg.dies = base_word[7:6];
         cfg.sock = base_word[8];
      end
      cfg.start = 4'(SEL_BASE_BIT) + {1'b0, sel};
      case (code)
         4'd0:  cfg.chan = 3'd0;
         4'd1:  cfg.chan = 3'd1;
         4'd3:  cfg.chan = 3'd2;
         4'd5:  cfg.chan = 3'd3;
         4'd7:  cfg.chan = 3'd4;
         4'd8: begin
            if (legacy) begin
               cfg.chan   = 3'd1;
               cfg.hashed = 1'b1;
            end else begin
               cfg.chan   = 3'd5;
            end
         end
         4'd12: begin
            cfg.chan   = 3'd1;
            cfg.hashed = 1'b1;
         end
         4'd13: begin
            cfg.chan   = 3'd2;
            cfg.hashed = 1'b1;
            cfg.split  = 1'b1;
         end
         4'd14: begin
            cfg.chan   = 3'd3;
            cfg.hashed = 1'b1;
            cfg.split  = 1'b1;
         end
         default: bad_code = 1'b1;
      endcase
      total = {1'b0, cfg.chan} + {2'b0, cfg.dies} + {3'b0, cfg.sock};
      err   = bad_code
            | (cfg.hashed && (sel > 3'd1))
            | (int'(total) > MAX_ILV);
   end

endmodule

// File: rtl/dram_addr_denorm_gap.sv
module dram_addr_denorm_gap #(
   parameter int ADDR_W  = 48,
   parameter int MAX_ILV = 4
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [3:0]        start,
   input  logic [3:0]        total,
   input  logic              split,
   output logic [ADDR_W-1:0] addr_o
);
   import dram_addr_denorm_pkg::*;

   localparam int NV = MAX_ILV + 1;

   logic [ADDR_W-1:0] low_m, mid_m;
   logic [ADDR_W-1:0] keep_y, mid_z, hi_split, hi_cont;
   logic [ADDR_W-1:0] cand [NV];

   always_comb begin
      low_m    = ~({ADDR_W{1'b1}} << start);
      mid_m    = ~({ADDR_W{1'b1}} << SPLIT_HI_BIT) & ~low_m;
      keep_y   = addr_i & low_m;
      mid_z    = (addr_i & mid_m) << 1;
      hi_split = addr_i & ~(low_m | mid_m);
      hi_cont  = addr_i & ~low_m;
   end

   for (genvar n = 0; n < NV; n++) begin : g_shift
      assign cand[n] = split ? ((hi_split << n) | mid_z | keep_y)
                             : ((hi_cont  << n) | keep_y);
   end

   always_comb begin
      addr_o = addr_i;
      for (int i = 0; i < NV; i++) begin
         if (int'(total) == i) addr_o = cand[i];
      end
   end

endmodule

// File: rtl/dram_addr_denorm_fin.sv
module dram_addr_denorm_fin #(
   parameter int ADDR_W = 48,
   parameter int CS_W   = 4
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [31:0]       base_word,
   input  logic [31:0]       limit_word,
   input  logic [31:0]       hole_word,
   input  logic [CS_W-1:0]   cs_id,
   input  logic              cs_fill,
   input  logic [3:0]        start,
   output logic [ADDR_W-1:0] addr_o,
   output logic              over
);
   localparam logic [ADDR_W-1:0] FOUR_GIB = ADDR_W'(33'h1_0000_0000);

   logic [ADDR_W-1:0] base, hole_base, limit, sum, holed;

   always_comb begin
      base      = ADDR_W'({base_word[31:12], 28'd0});
      limit     = ADDR_W'({limit_word[31:12], 28'hFFF_FFFF});
      hole_base = ADDR_W'({hole_word[31:24], 24'd0});
      sum       = addr_i + base;
      if (base_word[1] && (sum >= hole_base)) holed = sum + (FOUR_GIB - hole_base);
      else                                    holed = sum;
      if (cs_fill) addr_o = holed | (ADDR_W'(cs_id) << start);
      else         addr_o = holed;
      over = addr_o > limit;
   end

endmodule

// File: rtl/dram_addr_denorm.sv
module dram_addr_denorm #(
   parameter int ADDR_W  = 48,
   parameter int CS_W    = 4,
   parameter int MAX_ILV = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_legacy,
   input  logic [ADDR_W-1:0] in_norm_addr,
   input  logic [CS_W-1:0]   in_cs_id,
   input  logic [31:0]       in_offset_word,
   input  logic [31:0]       in_base_word,
   input  logic [31:0]       in_limit_word,
   input  logic [31:0]       in_hole_word,
   output logic              out_valid,
   output logic [ADDR_W-1:0] out_sys_addr,
   output logic              out_err
);
   import dram_addr_denorm_pkg::*;

   if (ADDR_W < 48) begin : g_aw_chk
      $error("ADDR_W must hold the 48-bit base and limit fields");
   end
   if (MAX_ILV < 1 || MAX_ILV > 8) begin : g_ilv_chk
      $error("MAX_ILV out of range");
   end

   logic [ADDR_W-1:0] stripped, gapped, final_addr;
   ilv_cfg_t          cfg;
   logic [3:0]        total;
   logic              dec_err, lim_err, cs_fill;

   dram_addr_denorm_ofs #(.ADDR_W(ADDR_W)) u_ofs (
      .legacy   (in_legacy),
      .ofs_word (in_offset_word),
      .addr_i   (in_norm_addr),
      .addr_o   (stripped)
   );

   dram_addr_denorm_dec #(.MAX_ILV(MAX_ILV)) u_dec (
      .legacy     (in_legacy),
      .base_word  (in_base_word),
      .limit_word (in_limit_word),
      .cfg        (cfg),
      .total      (total),
      .err        (dec_err)
   );

   dram_addr_denorm_gap #(.ADDR_W(ADDR_W), .MAX_ILV(MAX_ILV)) u_gap (
      .addr_i (stripped),
      .start  (cfg.start),
      .total  (total),
      .split  (cfg.split),
      .addr_o (gapped)
   );

   assign cs_fill = !cfg.hashed && (cfg.chan != 3'd0);

   dram_addr_denorm_fin #(.ADDR_W(ADDR_W), .CS_W(CS_W)) u_fin (
      .addr_i     (gapped),
      .base_word  (in_base_word),
      .limit_word (in_limit_word),
      .hole_word  (in_hole_word),
      .cs_id      (in_cs_id),
      .cs_fill    (cs_fill),
      .start      (cfg.start),
      .addr_o     (final_addr),
      .over       (lim_err)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid    <= 1'b0;
         out_sys_addr <= '0;
         out_err      <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_sys_addr <= final_addr;
            out_err      <= dec_err | lim_err;
         end
      end
   end

endmodule

// File: rtl/dram_addr_denorm_chk.sv
module dram_addr_denorm_chk #(
   parameter int ADDR_W = 48,
   parameter int CS_W   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_legacy,
   input logic [ADDR_W-1:0] in_norm_addr,
   input logic [31:0]       in_offset_word,
   input logic [31:0]       in_base_word,
   input logic [31:0]       in_limit_word,
   input logic              out_valid,
   input logic [ADDR_W-1:0] out_sys_addr,
   input logic              out_err
);
   // R1
   rst_quiet_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

   // R2
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R2
   idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   // R6
   bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_legacy && in_base_word[7:4] == 4'd2) |=> out_err);

   // R7
   hash_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_legacy && in_base_word[5:2] == 4'd12
       && in_base_word[11:9] >= 3'd2) |=> out_err);

   // R9
   plain_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_legacy && in_base_word == 32'd0 && !in_offset_word[0]
       && in_limit_word[11:8] == 4'd0) |=> (out_sys_addr == $past(in_norm_addr)));

   // R13
   limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_err) |->
         (out_sys_addr <= ADDR_W'({$past(in_limit_word[31:12]), 28'hFFF_FFFF})));

endmodule

bind dram_addr_denorm dram_addr_denorm_chk #(.ADDR_W(ADDR_W), .CS_W(CS_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .in_valid       (in_valid),
   .in_legacy      (in_legacy),
   .in_norm_addr   (in_norm_addr),
   .in_offset_word (in_offset_word),
   .in_base_word   (in_base_word),
   .in_limit_word  (in_limit_word),
   .out_valid      (out_valid),
   .out_sys_addr   (out_sys_addr),
   .out_err        (out_err)
);

// File: tb/dram_addr_denorm_test.sv
module dram_addr_denorm_test;
   localparam int AW = 48;
   localparam int CW = 4;
   localparam logic [31:0] LIM_ALL = 32'hFFFF_F000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_legacy = 1'b0;
   logic [AW-1:0] in_norm_addr = '0;
   logic [CW-1:0] in_cs_id = '0;
   logic [31:0]   in_offset_word = '0;
   logic [31:0]   in_base_word = '0;
   logic [31:0]   in_limit_word = '0;
   logic [31:0]   in_hole_word = '0;
   logic          out_valid;
   logic [AW-1:0] out_sys_addr;
   logic          out_err;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [AW-1:0] exp_addr_q[$];
   logic          exp_err_q[$];
   string         tag_q[$];

   always #5 clk = ~clk;

   dram_addr_denorm #(.ADDR_W(AW), .CS_W(CW), .MAX_ILV(4)) uut (
      .clk            (clk),
      .rst_n          (rst_n),
      .in_valid       (in_valid),
      .in_legacy      (in_legacy),
      .in_norm_addr   (in_norm_addr),
      .in_cs_id       (in_cs_id),
      .in_offset_word (in_offset_word),
      .in_base_word   (in_base_word),
      .in_limit_word  (in_limit_word),
      .in_hole_word   (in_hole_word),
      .out_valid      (out_valid),
      .out_sys_addr   (out_sys_addr),
      .out_err        (out_err)
   );

   task automatic send(input logic lg, input logic [AW-1:0] na, input logic [CW-1:0] cs,
                       input logic [31:0] ofs, input logic [31:0] base,
                       input logic [31:0] lim, input logic [31:0] hole,
                       input logic e_err, input logic [AW-1:0] e_addr, input string tag);
      @(negedge clk);
      in_valid       = 1'b1;
      in_legacy      = lg;
      in_norm_addr   = na;
      in_cs_id       = cs;
      in_offset_word = ofs;
      in_base_word   = base;
      in_limit_word  = lim;
      in_hole_word   = hole;
      exp_addr_q.push_back(e_addr);
      exp_err_q.push_back(e_err);
      tag_q.push_back(tag);
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // Monitor / scoreboard: outputs are sampled on the falling edge.
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && out_valid) begin
            checks++;
            if (exp_err_q.size() == 0) begin
               errors++;
               $display("FAIL R2 unexpected result addr=%h err=%b expected none", out_sys_addr, out_err);
            end else begin
               logic [AW-1:0] ea;
               logic          ee;
               string         tg;
               ea = exp_addr_q.pop_front();
               ee = exp_err_q.pop_front();
               tg = tag_q.pop_front();
               if (out_err !== ee || (!ee && out_sys_addr !== ea)) begin
                  errors++;
                  $display("FAIL %s addr=%h err=%b expected addr=%h err=%b",
                           tg, out_sys_addr, out_err, ea, ee);
               end
            end
         end
      end
   end

   initial begin
      #2_000_000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
         errors++;
         $display("FAIL R1 out_valid=%b expected 0", out_valid);
      end
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
         errors++;
         $display("FAIL R1 out_valid after reset=%b expected 0", out_valid);
      end

      // R9 plain pass-through
      send(1, 48'h12_3456, 0, 0, 0, LIM_ALL, 0, 0, 48'h12_3456, "R9 pass");
      // R3 offset legacy and new field positions
      send(1, 48'h1000_0100, 0, 32'h0010_0001, 0, LIM_ALL, 0, 0, 48'h100, "R3 ofs legacy");
      send(0, 48'h3000_0040, 0, 32'h0000_3001, 0, LIM_ALL, 0, 0, 48'h40, "R3 ofs new");
      send(1, 48'h3000_0040, 0, 32'h0000_3001, 0, LIM_ALL, 0, 0, 48'h3000_0040, "R3 ofs legacy narrow");
      // R4 offset not applied
      send(1, 48'h1000_0000, 0, 32'h0020_0001, 0, LIM_ALL, 0, 0, 48'h1000_0000, "R4 below ofs");
      send(1, 48'h1000_0100, 0, 32'h0010_0000, 0, LIM_ALL, 0, 0, 48'h1000_0100, "R4 ofs disabled");
      idle();
      // R2 idle gap then back-to-back
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
         errors++;
         $display("FAIL R2 out_valid=%b expected 0 after idle", out_valid);
      end
      // R9 R11 contiguous gap, cs fill
      send(1, 48'h1234, 4'h1, 0, 32'h10, LIM_ALL, 0, 0, 48'h2534, "R11 legacy 1ch cs");
      send(0, 48'h3FF, 4'hA, 0, 32'h21C, LIM_ALL, 0, 0, 48'h35FF, "R9 new 4bit start9");
      // R10 split
      send(0, 48'hFFF, 4'h3, 0, 32'h34, LIM_ALL, 0, 0, 48'h2EFF, "R10 split 2bit");
      send(1, 48'hABC, 4'h7, 0, 32'h1E0, LIM_ALL, 0, 0, 48'h44BC, "R10 split 3bit start9");
      // R5 code 8 in both layouts, dies/sockets fields
      send(1, 48'h1FF, 4'h1, 0, 32'h80, LIM_ALL, 0, 0, 48'h2FF, "R5 legacy code8 hashed");
      send(0, 48'h1FF, 4'h1, 0, 32'h20, LIM_ALL, 0, 1, 48'h0, "R8 new code8 five bits");
      send(0, 48'hFFFF, 4'h3, 0, 32'h144, LIM_ALL, 0, 0, 48'h7_FBFF, "R5 new die+socket");
      send(1, 48'h1_0000, 4'h5, 0, 32'h50, 32'hFFFF_F400, 0, 0, 48'h10_0500, "R8 total four ok");
      // R6 R7 R8 errors
      send(1, 48'h100, 0, 0, 32'h20, LIM_ALL, 0, 1, 48'h0, "R6 bad code");
      send(0, 48'h100, 0, 0, 32'h430, LIM_ALL, 0, 1, 48'h0, "R7 hashed start10");
      send(1, 48'h3FF, 4'h1, 0, 32'h1C0, LIM_ALL, 0, 0, 48'h5FF, "R7 hashed start9 ok");
      send(1, 48'h100, 0, 0, 32'h70, 32'hFFFF_F100, 0, 1, 48'h0, "R8 total five");
      // R11 base add
      send(1, 48'h40, 0, 0, 32'h0001_0000, LIM_ALL, 0, 0, 48'h1_0000_0040, "R11 base");
      // R12 hole
      send(1, 48'hD000_0000, 0, 0, 32'h2, LIM_ALL, 32'hC000_0000, 0, 48'h1_1000_0000, "R12 above hole");
      send(1, 48'hC000_0000, 0, 0, 32'h2, LIM_ALL, 32'hC000_0000, 0, 48'h1_0000_0000, "R12 at hole");
      send(1, 48'hBFFF_FFFF, 0, 0, 32'h2, LIM_ALL, 32'hC000_0000, 0, 48'hBFFF_FFFF, "R12 below hole");
      send(1, 48'hD000_0000, 0, 0, 32'h0, LIM_ALL, 32'hC000_0000, 0, 48'hD000_0000, "R12 hole off");
      // R13 limit
      send(1, 48'h1000_0000, 0, 0, 0, 32'h0, 0, 1, 48'h0, "R13 above limit");
      send(1, 48'h0FFF_FFFF, 0, 0, 0, 32'h0, 0, 0, 48'h0FFF_FFFF, "R13 at limit");
      idle();
      repeat (4) @(negedge clk);
      checks++;
      if (exp_err_q.size() != 0) begin
         errors++;
         $display("FAIL R2 results missing=%0d expected 0", exp_err_q.size());
      end
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule